// File: doc/BRIEF.md
# Secondary-processor boot release mailbox

This block is a small memory-mapped table through which a primary processor parks and then launches up to 32 secondary processors. Each secondary owns one 32-byte slot. The slot holds a 64-bit launch address, a 64-bit value for the first argument register, the processor's identity word and two spare fields. Software reads and writes the table over a simple valid/ready slave port in single accesses of 1, 2 or 4 bytes. Multi-byte fields are stored with the most significant byte at the lowest address.

A slot is armed while bit 0 of its launch address is 1. After every accepted write to a slot, the block looks at that bit. If the bit is 0, it issues a one-cycle release pulse for that processor. With the pulse it gives:

- the launch address split at a 64 MiB boundary into a mapping base and a start offset,
- the mapping size,
- the argument value.

In the same step, the slot's identity field is replaced with the processor's real hardware ID. The start-up sequencing of the processor and the programming of its translation hardware belong to the consumer of the pulse.

Top module: `spin_mbox`

## Requirements
- R1: After reset, slot i holds launch address 1, argument i and identity i. All other bytes are 0.
- R2: Byte address bits [9:5] select slot i and bits [4:0] select the byte in the slot. The launch address sits at bytes 0-7, the argument at bytes 8-15 and the identity word at bytes 20-23; bytes 16-19 and 24-31 are spare. All fields are stored big-endian, most significant byte first.
- R3: A write with size code 0, 1 or 2 stores 1, 2 or 4 bytes, taken right-justified from bus_wdata. The most significant of those bytes goes to the lowest address. The low address bits are forced to natural alignment, and no other byte changes.
- R4: A read with size code 0, 1 or 2 gives rd_valid one cycle after acceptance, with the bytes right-justified and big-endian in rd_data and the upper bits 0. Any slot can be read, including slot 0 and absent processors.
- R5: A read with size code 3 gives rd_valid together with rd_err and rd_data equal to 0.
- R6: A write that selects slot 0 changes nothing and raises no release.
- R7: A write that selects a slot whose cpu_present bit is 0 changes nothing and raises no release.
- R8: One cycle after an accepted write, release_pulse[i] is high for exactly one cycle if bit 0 of slot i's launch address, after the write, is 0. Otherwise no pulse is raised.
- R9: In the pulse cycle, rel_offset equals the launch address AND (2^26-1), rel_base equals the launch address with those bits cleared, rel_size equals 2^26, and rel_arg equals the slot's argument after the write. These outputs hold between pulses.
- R10: On a release, bytes 20-23 of the slot take cpu_hw_id[32*i +: 32]. This overrides any bytes that the same write put there.
- R11: Every further accepted write to a slot whose launch address bit 0 is still 0 raises the pulse again. A write with size code 3 stores nothing but still counts as an accepted write.
- R12: bus_ready is always 1, so every bus_valid cycle is accepted. Accesses may run back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_valid | input | 1 | Access request |
| bus_ready | output | 1 | Access accepted (always 1) |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 10 | Byte address in the table |
| bus_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 invalid |
| bus_wdata | input | 32 | Write data, right-justified |
| cpu_present | input | 32 | One bit per processor that exists |
| cpu_hw_id | input | 1024 | Hardware ID of processor i at bits [32*i +: 32] |
| rd_valid | output | 1 | Read response valid |
| rd_data | output | 32 | Read data, right-justified |
| rd_err | output | 1 | Read used an invalid size |
| release_pulse | output | 32 | One-cycle release per processor |
| rel_offset | output | 64 | Start offset inside the mapping |
| rel_base | output | 64 | 64 MiB-aligned mapping base |
| rel_size | output | 64 | Mapping size |
| rel_arg | output | 64 | First-argument value |

## Verification
The assertions check several properties on every cycle:

- Processor 0 is never released, and at most one release bit is set at a time.
- A pulse and a read response each follow an accepted access of the matching kind.
- An error response carries zero data.
- A slot's contents stay unchanged when it is not written.
- The identity field takes the hardware ID on the edge after a release.

Only the bench's scenarios can show the rest: big-endian placement and alignment of partial accesses, the split of the launch address into base and offset, ignored writes to slot 0 and to absent processors, repeated and invalid-size writes that fire again, and an identity write that the release overrides.

// File: rtl/spin_mbox_pkg.sv
// Shared constants and helpers for the boot release mailbox.
// Assumes 32-byte slots with a fixed field layout.
package spin_mbox_pkg;

    localparam int SLOT_BYTES = 32;
    localparam int SLOT_OFF_W = 5;
    localparam int LAUNCH_OFS = 0;
    localparam int ARG_OFS    = 8;
    localparam int IDENT_OFS  = 20;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_BAD  = 2'd3
    } acc_size_e;

    // Number of bytes moved by a size code (0 for the invalid code).
    function automatic int size_bytes(input logic [1:0] sz);
        case (sz)
            SZ_BYTE: return 1;
            SZ_HALF: return 2;
            SZ_WORD: return 4;
            default: return 0;
        endcase
    endfunction

    // Force an in-slot offset to the natural alignment of the access.
    function automatic logic [SLOT_OFF_W-1:0] align_off(input logic [SLOT_OFF_W-1:0] off,
                                                        input logic [1:0] sz);
        case (sz)
            SZ_BYTE: return off;
            SZ_HALF: return {off[SLOT_OFF_W-1:1], 1'b0};
            default: return {off[SLOT_OFF_W-1:2], 2'b00};
        endcase
    endfunction

    // Reset value of byte k in slot idx: launch = 1, argument = idx, identity = idx.
    function automatic logic [7:0] reset_byte(input int idx, input int k);
        logic [31:0] v;
        v = idx;
        if (k == LAUNCH_OFS + 7)     return 8'h01;
        else if (k == ARG_OFS + 7)   return v[7:0];
        else if (k == IDENT_OFS + 3) return v[7:0];
        else                         return 8'h00;
    endfunction

endpackage

// File: rtl/spin_mbox_decode.sv
// Address decode: turns a bus access into a per-slot write select and read controls.
// Assumes a single access per cycle; slot 0 and absent processors never get a select.
module spin_mbox_decode #(
    parameter int NUM_CPUS = 32,
    localparam int IDX_W  = $clog2(NUM_CPUS),
    localparam int ADDR_W = IDX_W + spin_mbox_pkg::SLOT_OFF_W
) (
    input  logic                                bus_valid,
    input  logic                                bus_write,
    input  logic [ADDR_W-1:0]                   bus_addr,
    input  logic [1:0]                          bus_size,
    input  logic [NUM_CPUS-1:0]                 cpu_present,
    output logic [NUM_CPUS-1:0]                 wr_sel,
    output logic                                rd_en,
    output logic                                rd_bad,
    output logic [IDX_W-1:0]                    slot_idx,
    output logic [spin_mbox_pkg::SLOT_OFF_W-1:0] slot_off
);
    import spin_mbox_pkg::*;

    logic wr_go;

    // Split the address and align the in-slot offset.
    always_comb begin
        slot_idx = bus_addr[ADDR_W-1:SLOT_OFF_W];
        slot_off = align_off(bus_addr[SLOT_OFF_W-1:0], bus_size);
        wr_go    = bus_valid && bus_write;
        rd_en    = bus_valid && !bus_write;
        rd_bad   = (bus_size == SZ_BAD);
    end

    // Per-slot write select, excluding the primary processor and absent ones.
    always_comb begin
        for (int i = 0; i < NUM_CPUS; i++) begin
            wr_sel[i] = wr_go && (int'(slot_idx) == i) && (i != 0) && cpu_present[i];
        end
    end

endmodule

// File: rtl/spin_mbox_entry.sv
// One 32-byte slot: byte-merge of writes, release detection, identity overwrite, read extract.
// Assumes the offset is already aligned to the access size.
module spin_mbox_entry #(
    parameter int IDX = 1
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                wr_sel,
    input  logic [spin_mbox_pkg::SLOT_OFF_W-1:0] acc_off,
    input  logic [1:0]                          acc_size,
    input  logic [31:0]                         wr_data,
    input  logic [31:0]                         id_val,
    output logic                                fire,
    output logic [63:0]                         nxt_launch,
    output logic [63:0]                         nxt_arg,
    output logic [31:0]                         rd_word
);
    import spin_mbox_pkg::*;

    logic [7:0]  mem_q [SLOT_BYTES];
    logic [7:0]  nxt_b [SLOT_BYTES];
    logic [255:0] img;
    logic [31:0] id_now;

    // Merge the write bytes into a copy of the slot, big-endian.
    always_comb begin
        int n;
        int o;
        n = size_bytes(acc_size);
        o = int'(acc_off);
        for (int k = 0; k < SLOT_BYTES; k++) begin
            nxt_b[k] = mem_q[k];
            if (wr_sel && k >= o && k < o + n) begin
                nxt_b[k] = wr_data[8*(n-1-(k-o)) +: 8];
            end
        end
    end

    // Assemble the post-write launch address and argument fields.
    always_comb begin
        for (int b = 0; b < 8; b++) begin
            nxt_launch[8*(7-b) +: 8] = nxt_b[LAUNCH_OFS + b];
            nxt_arg[8*(7-b) +: 8]    = nxt_b[ARG_OFS + b];
        end
    end

    // Release when the slot is written and the armed bit ends up clear.
    always_comb fire = wr_sel && !nxt_launch[0];

    // Commit the merged slot; on release the identity bytes take the hardware ID.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < SLOT_BYTES; k++) mem_q[k] <= reset_byte(IDX, k);
        end else if (wr_sel) begin
            for (int k = 0; k < SLOT_BYTES; k++) begin
                if (fire && k >= IDENT_OFS && k < IDENT_OFS + 4)
                    mem_q[k] <= id_val[8*(IDENT_OFS+3-k) +: 8];
                else
                    mem_q[k] <= nxt_b[k];
            end
        end
    end

    // Extract the addressed bytes for a read, right-justified.
    always_comb begin
        int n;
        int o;
        n = size_bytes(acc_size);
        o = int'(acc_off);
        rd_word = '0;
        for (int j = 0; j < 4; j++) begin
            if (j < n && o + j < SLOT_BYTES) rd_word[8*(n-1-j) +: 8] = mem_q[o+j];
        end
    end

    // Flattened views used by the checks below.
    always_comb begin
        for (int k = 0; k < SLOT_BYTES; k++) img[8*(SLOT_BYTES-1-k) +: 8] = mem_q[k];
        id_now = {mem_q[IDENT_OFS], mem_q[IDENT_OFS+1], mem_q[IDENT_OFS+2], mem_q[IDENT_OFS+3]};
    end

    // R10
    ident_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> id_now == $past(id_val));

    // R7
    slot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_sel |=> $stable(img));

endmodule

// File: rtl/spin_mbox_release.sv
// Registers the release pulse vector and the launch parameters of the fired slot.
// Assumes at most one slot fires per cycle; outputs hold their last values between pulses.
module spin_mbox_release #(
    parameter int NUM_CPUS = 32,
    parameter int MAP_LOG2 = 26,
    localparam int IDX_W = $clog2(NUM_CPUS)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_CPUS-1:0]      fire,
    input  logic [NUM_CPUS*64-1:0]   launch_flat,
    input  logic [NUM_CPUS*64-1:0]   arg_flat,
    input  logic [IDX_W-1:0]         slot_idx,
    output logic [NUM_CPUS-1:0]      rel_pulse,
    output logic [63:0]              rel_offset,
    output logic [63:0]              rel_base,
    output logic [63:0]              rel_size,
    output logic [63:0]              rel_arg
);
    localparam logic [63:0] MAP_MASK = (64'd1 << MAP_LOG2) - 64'd1;

    logic [63:0] launch_q;
    logic [63:0] arg_q;

    // Capture the pulse and the parameters of the slot that fired.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rel_pulse <= '0;
            launch_q  <= '0;
            arg_q     <= '0;
        end else begin
            rel_pulse <= fire;
            if (|fire) begin
                launch_q <= launch_flat[int'(slot_idx)*64 +: 64];
                arg_q    <= arg_flat[int'(slot_idx)*64 +: 64];
            end
        end
    end

    // Split the launch address at the mapping boundary.
    always_comb begin
        rel_offset = launch_q & MAP_MASK;
        rel_base   = launch_q & ~MAP_MASK;
        rel_size   = MAP_MASK + 64'd1;
        rel_arg    = arg_q;
    end

    // R8
    one_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rel_pulse));

endmodule

// File: rtl/spin_mbox_rdresp.sv
// Read response stage: picks the addressed slot's word and registers it with one cycle latency.
// Assumes the slot word is already extracted and right-justified.
module spin_mbox_rdresp #(
    parameter int NUM_CPUS = 32,
    localparam int IDX_W = $clog2(NUM_CPUS)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    rd_en,
    input  logic                    rd_bad,
    input  logic [IDX_W-1:0]        slot_idx,
    input  logic [NUM_CPUS*32-1:0]  word_flat,
    output logic                    rd_valid,
    output logic [31:0]             rd_data,
    output logic                    rd_err
);
    // Register the response; invalid sizes return zero with the error flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
            rd_err   <= 1'b0;
        end else begin
            rd_valid <= rd_en;
            rd_err   <= rd_en && rd_bad;
            rd_data  <= (rd_en && !rd_bad) ? word_flat[int'(slot_idx)*32 +: 32] : 32'd0;
        end
    end

    // R5
    err_has_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_err |-> rd_valid);

    // R5
    err_zero_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_err |-> rd_data == 32'd0);

endmodule

// File: rtl/spin_mbox.sv
// Top of the boot release mailbox: decode, one slot per processor, read response, release output.
// Assumes one bus access per cycle, always accepted.
module spin_mbox #(
    parameter int NUM_CPUS = 32,
    parameter int MAP_LOG2 = 26,
    localparam int IDX_W  = $clog2(NUM_CPUS),
    localparam int ADDR_W = IDX_W + spin_mbox_pkg::SLOT_OFF_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    bus_valid,
    output logic                    bus_ready,
    input  logic                    bus_write,
    input  logic [ADDR_W-1:0]       bus_addr,
    input  logic [1:0]              bus_size,
    input  logic [31:0]             bus_wdata,
    input  logic [NUM_CPUS-1:0]     cpu_present,
    input  logic [NUM_CPUS*32-1:0]  cpu_hw_id,
    output logic                    rd_valid,
    output logic [31:0]             rd_data,
    output logic                    rd_err,
    output logic [NUM_CPUS-1:0]     release_pulse,
    output logic [63:0]             rel_offset,
    output logic [63:0]             rel_base,
    output logic [63:0]             rel_size,
    output logic [63:0]             rel_arg
);
    import spin_mbox_pkg::*;

    logic [NUM_CPUS-1:0]      wr_sel;
    logic [NUM_CPUS-1:0]      fire;
    logic                     rd_en;
    logic                     rd_bad;
    logic [IDX_W-1:0]         slot_idx;
    logic [SLOT_OFF_W-1:0]    slot_off;
    logic [31:0]              sel_id;
    logic [NUM_CPUS*64-1:0]   launch_flat;
    logic [NUM_CPUS*64-1:0]   arg_flat;
    logic [NUM_CPUS*32-1:0]   word_flat;

    // The table never stalls the bus.
    always_comb bus_ready = 1'b1;

    // Hardware ID of the addressed processor, used if its slot fires.
    always_comb sel_id = cpu_hw_id[int'(slot_idx)*32 +: 32];

    spin_mbox_decode #(.NUM_CPUS(NUM_CPUS)) u_decode (
        .bus_valid   (bus_valid),
        .bus_write   (bus_write),
        .bus_addr    (bus_addr),
        .bus_size    (bus_size),
        .cpu_present (cpu_present),
        .wr_sel      (wr_sel),
        .rd_en       (rd_en),
        .rd_bad      (rd_bad),
        .slot_idx    (slot_idx),
        .slot_off    (slot_off)
    );

    for (genvar g = 0; g < NUM_CPUS; g++) begin : g_slot
        spin_mbox_entry #(.IDX(g)) u_entry (
            .clk        (clk),
            .rst_n      (rst_n),
            .wr_sel     (wr_sel[g]),
            .acc_off    (slot_off),
            .acc_size   (bus_size),
            .wr_data    (bus_wdata),
            .id_val     (sel_id),
            .fire       (fire[g]),
            .nxt_launch (launch_flat[g*64 +: 64]),
            .nxt_arg    (arg_flat[g*64 +: 64]),
            .rd_word    (word_flat[g*32 +: 32])
        );
    end

    spin_mbox_rdresp #(.NUM_CPUS(NUM_CPUS)) u_rdresp (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_en     (rd_en),
        .rd_bad    (rd_bad),
        .slot_idx  (slot_idx),
        .word_flat (word_flat),
        .rd_valid  (rd_valid),
        .rd_data   (rd_data),
        .rd_err    (rd_err)
    );

    spin_mbox_release #(.NUM_CPUS(NUM_CPUS), .MAP_LOG2(MAP_LOG2)) u_release (
        .clk         (clk),
        .rst_n       (rst_n),
        .fire        (fire),
        .launch_flat (launch_flat),
        .arg_flat    (arg_flat),
        .slot_idx    (slot_idx),
        .rel_pulse   (release_pulse),
        .rel_offset  (rel_offset),
        .rel_base    (rel_base),
        .rel_size    (rel_size),
        .rel_arg     (rel_arg)
    );

    // R6
    no_primary_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !release_pulse[0]);

    // R8
    pulse_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|release_pulse) |-> $past(bus_valid && bus_write));

    // R4
    resp_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(bus_valid && !bus_write));

endmodule

// File: tb/spin_mbox_bench.sv
// Scoreboard bench: driver tasks update a byte model and queue expected responses;
// a monitor pops and compares them in the cycle they are due.
module spin_mbox_bench;

    localparam int N = 32;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            bus_valid = 1'b0;
    logic            bus_ready;
    logic            bus_write = 1'b0;
    logic [9:0]      bus_addr = '0;
    logic [1:0]      bus_size = '0;
    logic [31:0]     bus_wdata = '0;
    logic [N-1:0]    cpu_present = 32'h7FFF_FFFF;
    logic [N*32-1:0] cpu_hw_id;
    logic            rd_valid;
    logic [31:0]     rd_data;
    logic            rd_err;
    logic [N-1:0]    release_pulse;
    logic [63:0]     rel_offset, rel_base, rel_size, rel_arg;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    typedef struct { int due; logic [31:0] data; logic err; string tag; } rd_exp_t;
    typedef struct { int due; int cpu; logic [63:0] launch; logic [63:0] arg; string tag; } rel_exp_t;

    rd_exp_t  rq[$];
    rel_exp_t lq[$];
    logic [7:0] mdl [N][32];

    spin_mbox u_spin_mbox (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_ready(bus_ready),
        .bus_write(bus_write), .bus_addr(bus_addr), .bus_size(bus_size),
        .bus_wdata(bus_wdata), .cpu_present(cpu_present), .cpu_hw_id(cpu_hw_id),
        .rd_valid(rd_valid), .rd_data(rd_data), .rd_err(rd_err),
        .release_pulse(release_pulse), .rel_offset(rel_offset), .rel_base(rel_base),
        .rel_size(rel_size), .rel_arg(rel_arg)
    );

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic int nb(input logic [1:0] sz);
        return (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : (sz == 2'd2) ? 4 : 0;
    endfunction

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Driver: one write per cycle, model update and release expectation.
    task automatic wr(input logic [9:0] a, input logic [1:0] sz, input logic [31:0] d,
                      input string tag);
        int idx, o, n;
        rel_exp_t e;
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_size = sz; bus_wdata = d;
        idx = int'(a[9:5]); o = int'(a[4:0]); n = nb(sz);
        if (n > 1) o = o & ~(n - 1);
        if (idx != 0 && cpu_present[idx]) begin
            for (int j = 0; j < n; j++) mdl[idx][o+j] = d[8*(n-1-j) +: 8];
            if (mdl[idx][7][0] == 1'b0) begin
                e.due = cyc + 1; e.cpu = idx; e.tag = tag;
                for (int b = 0; b < 8; b++) begin
                    e.launch[8*(7-b) +: 8] = mdl[idx][b];
                    e.arg[8*(7-b) +: 8]    = mdl[idx][8+b];
                end
                lq.push_back(e);
                for (int j = 0; j < 4; j++) mdl[idx][20+j] = cpu_hw_id[idx*32 + 8*(3-j) +: 8];
            end
        end
    endtask

    // Driver: one read per cycle, expected data from the model.
    task automatic rd(input logic [9:0] a, input logic [1:0] sz, input string tag);
        int idx, o, n;
        rd_exp_t e;
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a; bus_size = sz; bus_wdata = '0;
        idx = int'(a[9:5]); o = int'(a[4:0]); n = nb(sz);
        if (n > 1) o = o & ~(n - 1);
        e.due = cyc + 1; e.tag = tag; e.data = '0; e.err = (sz == 2'd3);
        for (int j = 0; j < n; j++) e.data[8*(n-1-j) +: 8] = mdl[idx][o+j];
        rq.push_back(e);
    endtask

    task automatic idle(input int k);
        for (int i = 0; i < k; i++) begin
            @(negedge clk);
            bus_valid = 1'b0; bus_write = 1'b0;
        end
    endtask

    // Monitor: compare due responses, flag unexpected ones.
    always @(negedge clk) begin
        if (rst_n) begin
            if (rq.size() > 0 && rq[0].due == cyc) begin
                rd_exp_t e;
                e = rq.pop_front();
                chk(rd_valid === 1'b1, e.tag, "rd_valid", {63'd0, rd_valid}, 64'd1);
                chk(rd_data === e.data, e.tag, "rd_data", {32'd0, rd_data}, {32'd0, e.data});
                chk(rd_err === e.err, e.tag, "rd_err", {63'd0, rd_err}, {63'd0, e.err});
            end else if (rd_valid !== 1'b0) begin
                chk(1'b0, "R4", "unexpected rd_valid", {63'd0, rd_valid}, 64'd0);
            end
            if (lq.size() > 0 && lq[0].due == cyc) begin
                rel_exp_t e;
                logic [63:0] m;
                e = lq.pop_front();
                m = (64'd1 << 26) - 64'd1;
                chk(release_pulse === (32'd1 << e.cpu), e.tag, "release_pulse",
                    {32'd0, release_pulse}, {32'd0, 32'd1 << e.cpu});
                chk(rel_offset === (e.launch & m), "R9", "rel_offset", rel_offset, e.launch & m);
                chk(rel_base === (e.launch & ~m), "R9", "rel_base", rel_base, e.launch & ~m);
                chk(rel_size === 64'h400_0000, "R9", "rel_size", rel_size, 64'h400_0000);
                chk(rel_arg === e.arg, "R9", "rel_arg", rel_arg, e.arg);
            end else if (release_pulse !== '0) begin
                chk(1'b0, "R8", "unexpected release_pulse", {32'd0, release_pulse}, 64'd0);
            end
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog expired actual=%0d expected=done", cyc);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < N; i++) cpu_hw_id[i*32 +: 32] = 32'hC0DE_0000 + 32'(i * 3);
        for (int i = 0; i < N; i++)
            for (int k = 0; k < 32; k++)
                mdl[i][k] = (k == 7) ? 8'h01 : (k == 15 || k == 23) ? 8'(i) : 8'h00;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        idle(1);
        chk(release_pulse === '0 && rd_valid === 1'b0, "R1", "reset outputs",
            {32'd0, release_pulse}, 64'd0);

        // R1 R2 R4: reset contents of several slots
        for (int i = 0; i < N; i += 5) begin
            rd(10'(i*32 + 4), 2'd2, "R1");
            rd(10'(i*32 + 0), 2'd2, "R1");
            rd(10'(i*32 + 12), 2'd2, "R1");
            rd(10'(i*32 + 20), 2'd2, "R2");
            rd(10'(i*32 + 16), 2'd2, "R1");
            rd(10'(i*32 + 28), 2'd2, "R1");
        end
        rd(10'(31*32 + 6), 2'd1, "R4");
        rd(10'(31*32 + 15), 2'd0, "R4");
        idle(2);

        // R6: writes to slot 0 are dropped
        wr(10'd4, 2'd2, 32'h0000_1000, "R6");
        wr(10'd12, 2'd2, 32'hDEAD_BEEF, "R6");
        rd(10'd4, 2'd2, "R6");
        rd(10'd12, 2'd2, "R6");
        // R7: writes to an absent processor are dropped
        wr(10'(31*32 + 4), 2'd2, 32'h0000_2000, "R7");
        rd(10'(31*32 + 4), 2'd2, "R7");
        idle(2);

        // R3: partial writes to slot 3, armed bit kept at 1
        wr(10'(3*32 + 8), 2'd1, 32'h0000_A1B2, "R3");
        wr(10'(3*32 + 11), 2'd0, 32'h0000_00C3, "R3");
        wr(10'(3*32 + 15), 2'd1, 32'h0000_D4E5, "R3");
        wr(10'(3*32 + 0), 2'd2, 32'h0000_0001, "R3");
        wr(10'(3*32 + 6), 2'd2, 32'h0ABC_DEF1, "R3");
        rd(10'(3*32 + 8), 2'd2, "R3");
        rd(10'(3*32 + 12), 2'd2, "R3");
        rd(10'(3*32 + 4), 2'd2, "R3");
        rd(10'(3*32 + 5), 2'd0, "R3");
        // R8 R9 R10: clearing bit 0 releases slot 3
        wr(10'(3*32 + 7), 2'd0, 32'h0000_00F0, "R8");
        rd(10'(3*32 + 20), 2'd2, "R10");
        idle(3);
        // R11: a further write releases again; invalid-size write also re-fires
        wr(10'(3*32 + 12), 2'd2, 32'h1234_5678, "R11");
        wr(10'(3*32 + 0), 2'd3, 32'hFFFF_FFFF, "R11");
        rd(10'(3*32 + 0), 2'd2, "R11");
        // R10: identity written by the same access is overridden by the hardware ID
        wr(10'(3*32 + 20), 2'd2, 32'h5555_AAAA, "R10");
        rd(10'(3*32 + 20), 2'd2, "R10");
        idle(2);

        // R12 R8: back-to-back releases of two slots
        wr(10'(7*32 + 4), 2'd2, 32'h07FF_FFF8, "R12");
        wr(10'(9*32 + 4), 2'd2, 32'hFC00_0010, "R12");
        wr(10'(9*32 + 0), 2'd2, 32'h8000_0000, "R12");
        rd(10'(7*32 + 20), 2'd2, "R12");
        idle(1);
        // R8: arming the slot again stops further releases
        wr(10'(7*32 + 7), 2'd0, 32'h0000_0001, "R8");
        wr(10'(7*32 + 8), 2'd2, 32'h0000_0077, "R8");
        rd(10'(7*32 + 4), 2'd2, "R8");
        // R5: invalid read size
        rd(10'(7*32 + 4), 2'd3, "R5");
        idle(4);

        chk(rq.size() == 0, "R4", "pending reads", 64'(rq.size()), 64'd0);
        chk(lq.size() == 0, "R8", "pending releases", 64'(lq.size()), 64'd0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule